// File: doc/BRIEF.md
# Memory-Management Fault Priority and Status Capture

This block sits beside the address translation logic of a memory management unit. On each checked access it receives one flag per fault source, a qualifier that tells whether the access resolved through a section (or a first-level table fetch) or through a page (or a second-level fetch), the access domain, the virtual address and whether the access was a data access or an instruction fetch. When one or more flags are raised, it chooses the fault with the highest fixed priority. It then forms a 4-bit status code and a 4-bit domain field and returns an abort to the core in the same cycle. It also tells the bus side that the external access must not go ahead.

On the following clock edge the status record is stored. A data access writes it to the data status register and also stores the virtual address in the address register. An instruction fetch writes it to the instruction status register only. All three registers can be read through a small select-and-read port. Table walking and permission evaluation happen elsewhere. This block only ranks and records their results.

Top module: `mmu_fault_capture`

## Requirements
- R1: After a synchronous active-low reset, the data status, instruction status and address registers all read as zero.
- R2: When several fault flags are set together, the recorded fault is the one highest in this order: alignment (flt_i bit 0), external abort during a table fetch (bit 1), translation (bit 2), domain (bit 3), permission (bit 4), external abort on the access (bit 5).
- R3: An alignment fault records status 4'b0011 and domain 0.
- R4: An external abort during a table fetch records 4'b1100 with domain 0 when page_i=0 (first level), and 4'b1110 with the input domain when page_i=1 (second level).
- R5: A translation fault records 4'b0101 with domain 0 for a section (page_i=0), and 4'b0111 with the input domain for a page.
- R6: A domain fault records 4'b1001 (section) or 4'b1011 (page). A permission fault records 4'b1101 (section) or 4'b1111 (page). In all four cases the input domain is recorded.
- R7: An external abort on the access records 4'b1000 (section) or 4'b1010 (page), with the input domain recorded.
- R8: A data abort (acc_data_i=1) writes the status register record as {domain[7:4], status[3:0]} into the data status register, and writes vaddr_i into the address register, one clock after the strobe.
- R9: An instruction abort (acc_data_i=0) writes the record into the instruction status register only. The data status register and the address register keep their values.
- R10: In the strobe cycle, abort_o is 1 and bus_go_o is 0 when any fault flag is set. With no flag set, abort_o is 0 and bus_go_o is 1. Both outputs are 0 when there is no strobe.
- R11: No register changes when the strobe is low, whatever the flags are, or when the strobe is high with no fault flag set.
- R12: rd_sel_i 0 reads the data status register, 1 reads the instruction status register, 2 reads the address register and 3 reads zero. The status registers are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_stb_i | input | 1 | Access being checked this cycle |
| acc_data_i | input | 1 | 1 = data access, 0 = instruction fetch |
| flt_i | input | 6 | Fault flags, bit 0 highest priority |
| page_i | input | 1 | 0 = section / first level, 1 = page / second level |
| dom_i | input | 4 | Domain of the access |
| vaddr_i | input | AW | Virtual address of the access |
| abort_o | output | 1 | Abort to the core |
| bus_go_o | output | 1 | External access may proceed |
| rd_sel_i | input | 2 | Register read select |
| rd_data_o | output | AW | Register read data |

## Verification
The bench raises every fault source alone under both qualifier values and checks each code and whether the domain is cleared. A design that swaps section and page codes, or that leaks the domain into an invalid-domain code, shows a wrong readback. It builds a cascade of flag sets in which each step drops the current top fault, so a misordered priority records the wrong code. It checks that instruction aborts leave the address and data status registers untouched, and that strobe-less or fault-free cycles change nothing. A design that always latches the address, or that captures on every strobe, is caught by these checks.

// File: rtl/mfc_pkg.sv
// Shared constants and types for the fault capture block.
// Assumes six fault sources indexed in priority order, index 0 highest.
package mfc_pkg;
    localparam int NSRC      = 6;
    localparam int CODE_W    = 4;
    localparam int DOM_W     = 4;

    localparam int SRC_ALIGN = 0;
    localparam int SRC_XEXT  = 1;
    localparam int SRC_XLAT  = 2;
    localparam int SRC_DOM   = 3;
    localparam int SRC_PERM  = 4;
    localparam int SRC_AEXT  = 5;

    localparam logic [CODE_W-1:0] ST_ALIGN    = 4'b0011;
    localparam logic [CODE_W-1:0] ST_XEXT_L1  = 4'b1100;
    localparam logic [CODE_W-1:0] ST_XEXT_L2  = 4'b1110;
    localparam logic [CODE_W-1:0] ST_XLAT_SEC = 4'b0101;
    localparam logic [CODE_W-1:0] ST_XLAT_PG  = 4'b0111;
    localparam logic [CODE_W-1:0] ST_DOM_SEC  = 4'b1001;
    localparam logic [CODE_W-1:0] ST_DOM_PG   = 4'b1011;
    localparam logic [CODE_W-1:0] ST_PERM_SEC = 4'b1101;
    localparam logic [CODE_W-1:0] ST_PERM_PG  = 4'b1111;
    localparam logic [CODE_W-1:0] ST_AEXT_SEC = 4'b1000;
    localparam logic [CODE_W-1:0] ST_AEXT_PG  = 4'b1010;

    localparam logic [1:0] SEL_DFSR = 2'd0;
    localparam logic [1:0] SEL_IFSR = 2'd1;
    localparam logic [1:0] SEL_FAR  = 2'd2;

    typedef struct packed {
        logic [DOM_W-1:0]  dom;
        logic [CODE_W-1:0] code;
    } fsr_t;

    localparam int FSR_W = $bits(fsr_t);
endpackage

// File: rtl/mfc_prio.sv
// Fault ranker and status encoder.
// Picks the lowest-index raised flag and encodes its status and domain.
// Assumes flags are already qualified by the access. This module is purely combinational.
module mfc_prio
    import mfc_pkg::*;
(
    input  logic [NSRC-1:0]  flt_i,
    input  logic             page_i,
    input  logic [DOM_W-1:0] dom_i,
    output logic             hit_o,
    output fsr_t             fsr_o
);
    logic [NSRC-1:0] win;
    logic [CODE_W-1:0] code;
    logic dom_ok;

    // One-hot winner: a flag wins when no higher-priority flag is raised.
    for (genvar i = 0; i < NSRC; i++) begin : g_win
        if (i == 0) begin : g_top
            assign win[i] = flt_i[i];
        end else begin : g_rest
            assign win[i] = flt_i[i] & ~(|flt_i[i-1:0]);
        end
    end

    assign hit_o = |flt_i;

    // Status code and domain-validity lookup for the winning source.
    always_comb begin
        code   = '0;
        dom_ok = 1'b0;
        if (win[SRC_ALIGN]) begin
            code   = ST_ALIGN;
            dom_ok = 1'b0;
        end
        if (win[SRC_XEXT]) begin
            code   = page_i ? ST_XEXT_L2 : ST_XEXT_L1;
            dom_ok = page_i;
        end
        if (win[SRC_XLAT]) begin
            code   = page_i ? ST_XLAT_PG : ST_XLAT_SEC;
            dom_ok = page_i;
        end
        if (win[SRC_DOM]) begin
            code   = page_i ? ST_DOM_PG : ST_DOM_SEC;
            dom_ok = 1'b1;
        end
        if (win[SRC_PERM]) begin
            code   = page_i ? ST_PERM_PG : ST_PERM_SEC;
            dom_ok = 1'b1;
        end
        if (win[SRC_AEXT]) begin
            code   = page_i ? ST_AEXT_PG : ST_AEXT_SEC;
            dom_ok = 1'b1;
        end
    end

    // Record assembly: an invalid domain is written as zero.
    always_comb begin
        fsr_o.code = code;
        fsr_o.dom  = dom_ok ? dom_i : '0;
    end

    // At most one source may win at a time.
    always_comb begin
        assert_one_winner_R2: assert ($onehot0(win));
    end
endmodule

// File: rtl/mfc_regs.sv
// Fault record storage: data status, instruction status and address registers.
// Assumes cap_i is already gated by the strobe and by a fault being present.
module mfc_regs
    import mfc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic          is_data_i,
    input  fsr_t          fsr_i,
    input  logic [AW-1:0] addr_i,
    output fsr_t          dfsr_o,
    output fsr_t          ifsr_o,
    output logic [AW-1:0] far_o
);
    // Data-side capture: status and faulting address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dfsr_o <= '0;
            far_o  <= '0;
        end else if (cap_i && is_data_i) begin
            dfsr_o <= fsr_i;
            far_o  <= addr_i;
        end
    end

    // Instruction-side capture: status only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifsr_o <= '0;
        end else if (cap_i && !is_data_i) begin
            ifsr_o <= fsr_i;
        end
    end

    assert_far_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && is_data_i) |=> (far_o == $past(addr_i)));
    assert_far_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_i && is_data_i) |=> $stable(far_o));
    assert_ifsr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_i && !is_data_i) |=> $stable(ifsr_o));
    assert_dfsr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_i && is_data_i) |=> $stable(dfsr_o));
endmodule

// File: rtl/mfc_rdmux.sv
// Register read selector. Status records are zero-extended to the port width.
// Assumes AW is at least the status record width.
module mfc_rdmux
    import mfc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]    sel_i,
    input  fsr_t          dfsr_i,
    input  fsr_t          ifsr_i,
    input  logic [AW-1:0] far_i,
    output logic [AW-1:0] data_o
);
    localparam int PAD_W = AW - FSR_W;

    // Select one register; the unused code reads zero.
    always_comb begin
        unique case (sel_i)
            SEL_DFSR: data_o = {{PAD_W{1'b0}}, dfsr_i};
            SEL_IFSR: data_o = {{PAD_W{1'b0}}, ifsr_i};
            SEL_FAR:  data_o = far_i;
            default:  data_o = '0;
        endcase
    end
endmodule

// File: rtl/mmu_fault_capture.sv
// Top of the fault capture block. It ranks the fault flags, drives the abort and
// bus-proceed outputs in the strobe cycle, and records the fault on the next edge.
// Assumes the flags, qualifier, domain and address are valid while acc_stb_i is high.
module mmu_fault_capture
    import mfc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_stb_i,
    input  logic            acc_data_i,
    input  logic [NSRC-1:0] flt_i,
    input  logic            page_i,
    input  logic [DOM_W-1:0] dom_i,
    input  logic [AW-1:0]   vaddr_i,
    output logic            abort_o,
    output logic            bus_go_o,
    input  logic [1:0]      rd_sel_i,
    output logic [AW-1:0]   rd_data_o
);
    logic hit;
    fsr_t rec;
    fsr_t dfsr;
    fsr_t ifsr;
    logic [AW-1:0] far;

    mfc_prio u_prio (
        .flt_i  (flt_i),
        .page_i (page_i),
        .dom_i  (dom_i),
        .hit_o  (hit),
        .fsr_o  (rec)
    );

    // Core and bus decisions for the checked access.
    always_comb begin
        abort_o  = acc_stb_i & hit;
        bus_go_o = acc_stb_i & ~hit;
    end

    mfc_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (abort_o),
        .is_data_i (acc_data_i),
        .fsr_i     (rec),
        .addr_i    (vaddr_i),
        .dfsr_o    (dfsr),
        .ifsr_o    (ifsr),
        .far_o     (far)
    );

    mfc_rdmux #(.AW(AW)) u_rdmux (
        .sel_i  (rd_sel_i),
        .dfsr_i (dfsr),
        .ifsr_i (ifsr),
        .far_i  (far),
        .data_o (rd_data_o)
    );

    assert_abort_blocks_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb_i && (flt_i != '0)) |-> (abort_o && !bus_go_o));
    assert_data_code_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && acc_data_i) |=> (dfsr.code != '0));
    assert_instr_code_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !acc_data_i) |=> (ifsr.code != '0));
endmodule

// File: tb/tb_mmu_fault_capture.sv
module tb_mmu_fault_capture;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic stb, isd, page;
    logic [5:0] flt;
    logic [3:0] dom;
    logic [AW-1:0] va;
    logic abort_w, go_w;
    logic [1:0] sel;
    logic [AW-1:0] rdat;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_dfsr, m_ifsr;
    logic [AW-1:0] m_far;

    always #10 clk = ~clk;

    mmu_fault_capture #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .acc_stb_i(stb), .acc_data_i(isd),
        .flt_i(flt), .page_i(page), .dom_i(dom), .vaddr_i(va),
        .abort_o(abort_w), .bus_go_o(go_w), .rd_sel_i(sel), .rd_data_o(rdat)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected record {domain, status} from the requirement tables.
    function automatic logic [7:0] want(input logic [5:0] f, input logic pg, input logic [3:0] d);
        if (f[0]) return 8'h03;
        if (f[1]) return pg ? {d, 4'b1110} : 8'h0C;
        if (f[2]) return pg ? {d, 4'b0111} : 8'h05;
        if (f[3]) return {d, pg ? 4'b1011 : 4'b1001};
        if (f[4]) return {d, pg ? 4'b1111 : 4'b1101};
        if (f[5]) return {d, pg ? 4'b1010 : 4'b1000};
        return 8'h00;
    endfunction

    task automatic rd(input logic [1:0] s, output logic [AW-1:0] v);
        sel = s;
        #1;
        v = rdat;
    endtask

    task automatic check_regs(input string tag);
        logic [AW-1:0] v;
        rd(2'd0, v); chk({tag, " dfsr"}, v, {24'h0, m_dfsr});
        rd(2'd1, v); chk({tag, " ifsr"}, v, {24'h0, m_ifsr});
        rd(2'd2, v); chk({tag, " far"},  v, m_far);
    endtask

    // One access cycle: check the same-cycle outputs, update the model, then read back.
    task automatic access(input string tag, input logic s, input logic [5:0] f,
                          input logic pg, input logic [3:0] d, input logic [AW-1:0] a,
                          input logic dat);
        @(negedge clk);
        stb = s; flt = f; page = pg; dom = d; va = a; isd = dat;
        #1;
        chk({tag, " R10 abort"}, {31'h0, abort_w}, {31'h0, s && (f != 0)});
        chk({tag, " R10 bus_go"}, {31'h0, go_w}, {31'h0, s && (f == 0)});
        if (s && f != 0) begin
            if (dat) begin
                m_dfsr = want(f, pg, d);
                m_far  = a;
            end else begin
                m_ifsr = want(f, pg, d);
            end
        end
        @(negedge clk);
        stb = 1'b0; flt = '0;
        check_regs(tag);
    endtask

    task automatic t_reset();
        m_dfsr = 0; m_ifsr = 0; m_far = 0;
        check_regs("R1 reset");
    endtask

    task automatic t_align();
        access("R3 align sec", 1, 6'b000001, 0, 4'hA, 32'h1000_0001, 1);
        access("R3 align pg",  1, 6'b000001, 1, 4'h5, 32'h1000_0003, 1);
    endtask

    task automatic t_xext();
        access("R4 xext l1", 1, 6'b000010, 0, 4'h7, 32'h2000_0000, 1);
        access("R4 xext l2", 1, 6'b000010, 1, 4'h7, 32'h2000_0010, 1);
    endtask

    task automatic t_xlat();
        access("R5 xlat sec", 1, 6'b000100, 0, 4'h9, 32'h3000_0000, 1);
        access("R5 xlat pg",  1, 6'b000100, 1, 4'h9, 32'h3000_0040, 1);
    endtask

    task automatic t_dom_perm();
        access("R6 dom sec",  1, 6'b001000, 0, 4'h3, 32'h4000_0000, 1);
        access("R6 dom pg",   1, 6'b001000, 1, 4'hC, 32'h4000_0100, 1);
        access("R6 perm sec", 1, 6'b010000, 0, 4'h6, 32'h5000_0000, 1);
        access("R6 perm pg",  1, 6'b010000, 1, 4'hE, 32'h5000_0200, 1);
    endtask

    task automatic t_aext();
        access("R7 aext sec", 1, 6'b100000, 0, 4'h2, 32'h6000_0000, 1);
        access("R7 aext pg",  1, 6'b100000, 1, 4'hD, 32'h6000_0400, 1);
    endtask

    // Drop the top flag at each step so every rank must win over all below it.
    task automatic t_priority();
        for (int k = 0; k < 6; k++) begin
            logic [5:0] f;
            f = 6'b111111 << k;
            access($sformatf("R2 prio sec k%0d", k), 1, f, 0, 4'hB, 32'h7000_0000 + k, 1);
            access($sformatf("R2 prio pg k%0d", k),  1, f, 1, 4'h4, 32'h7100_0000 + k, 0);
        end
    endtask

    task automatic t_instr();
        access("R9 instr xlat", 1, 6'b000100, 1, 4'h8, 32'hDEAD_BEEF, 0);
        access("R9 instr perm", 1, 6'b010000, 0, 4'h1, 32'hCAFE_0000, 0);
    endtask

    task automatic t_no_update();
        access("R11 no strobe", 0, 6'b000101, 1, 4'hF, 32'h8888_8888, 1);
        access("R11 no strobe instr", 0, 6'b100000, 0, 4'hF, 32'h9999_9999, 0);
        access("R11 no fault data", 1, 6'b000000, 1, 4'hF, 32'hAAAA_AAAA, 1);
        access("R11 no fault instr", 1, 6'b000000, 0, 4'hF, 32'hBBBB_BBBB, 0);
    endtask

    task automatic t_readsel();
        logic [AW-1:0] v;
        access("R12 setup", 1, 6'b001000, 1, 4'h5, 32'h0123_4567, 1);
        rd(2'd3, v);
        chk("R12 sel3 zero", v, 32'h0);
        rd(2'd2, v);
        chk("R12 sel2 far", v, 32'h0123_4567);
        rd(2'd0, v);
        chk("R12 sel0 dfsr", v, 32'h0000_005B);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; stb = 0; isd = 0; flt = 0; page = 0; dom = 0; va = 0; sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_align();
        t_xext();
        t_xlat();
        t_dom_perm();
        t_aext();
        t_priority();
        t_instr();
        t_no_update();
        t_readsel();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule